// File: doc/BRIEF.md
# I/O Device Status Word with Error Lockout

This block keeps the error status of one I/O module. While an I/O instruction runs, the execution logic reports the errors it finds as a 16-bit mask, qualified by an execute strobe. The block ORs each mask into a sticky device status word. Any error bit recorded for an instruction makes that instruction finish with condition code 01, so software learns of errors from the condition code. The block never raises an interrupt request.

Each command strobe carries a command kind, and each command gets exactly one condition code back. While the status word holds any set bit, the module is locked: every ordinary command is turned away with condition code 01 and changes nothing. Two commands stay allowed under lockout. A halt clears the word. A status read returns the word and clears it in the same step. A system reset also clears the word.

Top module: `iostat_dsw_unit`

## Requirements
- R1: After reset the status word is zero, and `cc_valid` and `rd_valid` are low. A status read issued right after reset returns zero.
- R2: An accepted command issued with `err_valid` high and a nonzero `err_bits` gets condition code 01. Those bits are recorded in the status word.
- R3: New error bits are ORed into the status word and never clear bits already set. Error bits that arrive while no command is present are recorded too.
- R4: While the status word is nonzero, an ordinary command gets condition code 01. Ordinary commands use `cmd_kind` 2'b00 or 2'b11.
- R5: A halt (`cmd_kind` 2'b10) is accepted even while locked, and it clears the status word. Without a new error its condition code is 00.
- R6: A status read (`cmd_kind` 2'b01) is accepted even while locked. It presents the status word as it stood before the command on `rd_data`, with `rd_valid` high, and clears the word. Without a new error its condition code is 00.
- R7: Error bits that arrive in the same cycle as a halt or a status read are kept in the status word after the clear.
- R8: An accepted command with no error bits gets condition code 00. Condition code 00 is encoded as 2'b00 and condition code 01 as 2'b01.
- R9: A rejected command has no side effect. The status word is unchanged, error bits presented with it are discarded, and `rd_valid` stays low.
- R10: `cc_valid`, `cc`, `rd_valid` and `rd_data` appear exactly one clock after the command strobe. `cc_valid` is high for one cycle per command and low in cycles that follow no command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low system reset; clears the status word |
| cmd_valid | input | 1 | Command strobe, one cycle per command |
| cmd_kind | input | 2 | 00/11 ordinary, 01 status read, 10 halt |
| err_valid | input | 1 | Execute strobe qualifying `err_bits` |
| err_bits | input | 16 | Error mask found during execution |
| cc_valid | output | 1 | Condition code strobe |
| cc | output | 2 | Condition code: 00 accepted, 01 error or rejected |
| rd_valid | output | 1 | Status read data strobe |
| rd_data | output | 16 | Status word returned by a status read |

## Verification
Every result of this block is due one clock after the command or error strobe that causes it: the condition code, the read data and the status word change. No result arrives two or more cycles later. The bench drives inputs on the falling edge and applies its reference model in the same step, then compares all four outputs on the next falling edge, half a cycle after the rising edge that registered them. Status word contents that have no direct port are checked through a later status read, so a dropped clear or a lost merge shows up on `rd_data` at that read.

// File: rtl/iostat_pkg.sv
`timescale 1ns/1ps
package iostat_pkg;

   typedef enum logic [1:0] {
      CMD_PLAIN     = 2'b00,
      CMD_RDSTAT    = 2'b01,
      CMD_HALT      = 2'b10,
      CMD_PLAIN_ALT = 2'b11
   } cmd_kind_e;

   localparam logic [1:0] CC_OK    = 2'b00;
   localparam logic [1:0] CC_FAULT = 2'b01;

   typedef struct packed {
      logic       merge_en;
      logic       clear;
      logic       rd_req;
      logic       cc_fire;
      logic [1:0] cc_val;
   } verdict_t;

endpackage

// File: rtl/iostat_cmd_gate.sv
`timescale 1ns/1ps
module iostat_cmd_gate
   import iostat_pkg::*;
#(
   parameter int DSW_W = 16
) (
   input  logic             cmd_valid,
   input  logic [1:0]       cmd_kind,
   input  logic             err_valid,
   input  logic [DSW_W-1:0] err_bits,
   input  logic             locked,
   output verdict_t         verdict
);

   logic is_plain;
   logic is_read;
   logic is_halt;
   logic reject;
   logic accept;
   logic new_fault;

   always_comb begin
      is_plain  = (cmd_kind == CMD_PLAIN) || (cmd_kind == CMD_PLAIN_ALT);
      is_read   = (cmd_kind == CMD_RDSTAT);
      is_halt   = (cmd_kind == CMD_HALT);
      reject    = cmd_valid && is_plain && locked;
      accept    = cmd_valid && !reject;
      new_fault = err_valid && (|err_bits);

      verdict.merge_en = err_valid && !reject;
      verdict.clear    = accept && (is_read || is_halt);
      verdict.rd_req   = accept && is_read;
      verdict.cc_fire  = cmd_valid;
      verdict.cc_val   = (reject || new_fault) ? CC_FAULT : CC_OK;
   end

endmodule

// File: rtl/iostat_dsw_store.sv
`timescale 1ns/1ps
module iostat_dsw_store #(
   parameter int DSW_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clear,
   input  logic             merge_en,
   input  logic [DSW_W-1:0] merge_bits,
   output logic [DSW_W-1:0] dsw_q,
   output logic             locked
);

   for (genvar b = 0; b < DSW_W; b++) begin : g_bit
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            dsw_q[b] <= 1'b0;
         else if (clear)
            dsw_q[b] <= merge_en & merge_bits[b];
         else if (merge_en & merge_bits[b])
            dsw_q[b] <= 1'b1;
      end
   end

   assign locked = |dsw_q;

   AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      !clear |=> ((dsw_q & $past(dsw_q)) == $past(dsw_q))) else $error("sticky bit lost"); // R3

   AST_MERGE_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
      merge_en |=> ((dsw_q & $past(merge_bits)) == $past(merge_bits))) else $error("merged bit missing"); // R7

endmodule

// File: rtl/iostat_resp.sv
`timescale 1ns/1ps
module iostat_resp #(
   parameter int DSW_W     = 16,
   parameter int OUT_STAGE = 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cc_fire,
   input  logic [1:0]       cc_val,
   input  logic             rd_req,
   input  logic [DSW_W-1:0] dsw_snap,
   output logic             cc_valid,
   output logic [1:0]       cc,
   output logic             rd_valid,
   output logic [DSW_W-1:0] rd_data
);

   if (OUT_STAGE != 0) begin : g_reg
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            cc_valid <= 1'b0;
            cc       <= 2'b00;
            rd_valid <= 1'b0;
            rd_data  <= '0;
         end else begin
            cc_valid <= cc_fire;
            cc       <= cc_fire ? cc_val : 2'b00;
            rd_valid <= rd_req;
            if (rd_req)
               rd_data <= dsw_snap;
         end
      end

      AST_READ_SNAPSHOT: assert property (@(posedge clk) disable iff (!rst_n)
         rd_req |=> (rd_valid && rd_data == $past(dsw_snap))) else $error("read snapshot"); // R6
   end else begin : g_comb
      always_comb begin
         cc_valid = cc_fire;
         cc       = cc_fire ? cc_val : 2'b00;
         rd_valid = rd_req;
         rd_data  = rd_req ? dsw_snap : '0;
      end
   end

endmodule

// File: rtl/iostat_dsw_unit.sv
`timescale 1ns/1ps
module iostat_dsw_unit
   import iostat_pkg::*;
#(
   parameter int DSW_W     = 16,
   parameter int OUT_STAGE = 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cmd_valid,
   input  logic [1:0]       cmd_kind,
   input  logic             err_valid,
   input  logic [DSW_W-1:0] err_bits,
   output logic             cc_valid,
   output logic [1:0]       cc,
   output logic             rd_valid,
   output logic [DSW_W-1:0] rd_data
);

   initial begin
      assert (DSW_W >= 1 && DSW_W <= 64) else $error("DSW_W out of range");
      assert (OUT_STAGE == 0 || OUT_STAGE == 1) else $error("OUT_STAGE must be 0 or 1");
   end

   verdict_t         verdict;
   logic [DSW_W-1:0] dsw_q;
   logic             locked;

   iostat_cmd_gate #(.DSW_W(DSW_W)) u_gate (
      .cmd_valid (cmd_valid),
      .cmd_kind  (cmd_kind),
      .err_valid (err_valid),
      .err_bits  (err_bits),
      .locked    (locked),
      .verdict   (verdict)
   );

   iostat_dsw_store #(.DSW_W(DSW_W)) u_store (
      .clk        (clk),
      .rst_n      (rst_n),
      .clear      (verdict.clear),
      .merge_en   (verdict.merge_en),
      .merge_bits (err_bits),
      .dsw_q      (dsw_q),
      .locked     (locked)
   );

   iostat_resp #(.DSW_W(DSW_W), .OUT_STAGE(OUT_STAGE)) u_resp (
      .clk      (clk),
      .rst_n    (rst_n),
      .cc_fire  (verdict.cc_fire),
      .cc_val   (verdict.cc_val),
      .rd_req   (verdict.rd_req),
      .dsw_snap (dsw_q),
      .cc_valid (cc_valid),
      .cc       (cc),
      .rd_valid (rd_valid),
      .rd_data  (rd_data)
   );

   if (OUT_STAGE != 0) begin : g_chk
      AST_REJECT_FAULT: assert property (@(posedge clk) disable iff (!rst_n)
         (cmd_valid && cmd_kind[1] == cmd_kind[0] && |dsw_q) |=> (cc_valid && cc == 2'b01)) else $error("reject cc"); // R4

      AST_REJECT_INERT: assert property (@(posedge clk) disable iff (!rst_n)
         (cmd_valid && cmd_kind[1] == cmd_kind[0] && |dsw_q) |=> ($stable(dsw_q) && !rd_valid)) else $error("reject side effect"); // R9

      AST_HALT_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
         (cmd_valid && cmd_kind == 2'b10 && !err_valid) |=> (dsw_q == '0 && cc == 2'b00)) else $error("halt clear"); // R5

      AST_ERR_FAULT_CC: assert property (@(posedge clk) disable iff (!rst_n)
         (cmd_valid && err_valid && |err_bits) |=> (cc_valid && cc == 2'b01)) else $error("error cc"); // R2

      AST_CC_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
         !cmd_valid |=> !cc_valid) else $error("spurious cc"); // R10
   end

endmodule

// File: tb/test_iostat_dsw_unit.sv
`timescale 1ns/1ps
module test_iostat_dsw_unit;

   localparam int W = 16;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         cmd_valid = 1'b0;
   logic [1:0]   cmd_kind = 2'b00;
   logic         err_valid = 1'b0;
   logic [W-1:0] err_bits = '0;
   logic         cc_valid;
   logic [1:0]   cc;
   logic         rd_valid;
   logic [W-1:0] rd_data;

   int vectors = 0;
   int fails   = 0;
   bit done    = 1'b0;

   logic [W-1:0] m_dsw;
   logic         x_ccv;
   logic [1:0]   x_cc;
   logic         x_rdv;
   logic [W-1:0] x_rd;
   string        x_tag;

   always #2 clk = ~clk;

   iostat_dsw_unit #(.DSW_W(W)) i_iostat_dsw_unit (
      .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_kind(cmd_kind),
      .err_valid(err_valid), .err_bits(err_bits), .cc_valid(cc_valid), .cc(cc),
      .rd_valid(rd_valid), .rd_data(rd_data)
   );

   function automatic logic is_plain(input logic [1:0] k);
      return (k == 2'b00) || (k == 2'b11);
   endfunction

   function automatic string pick_tag(input logic v, input logic [1:0] k,
                                      input logic ev, input logic [W-1:0] eb,
                                      input logic [W-1:0] d);
      if (!v)                        return "R10";
      if (is_plain(k) && d != '0)    return (ev ? "R9" : "R4");
      if (ev && eb != '0)            return ((k == 2'b01 || k == 2'b10) ? "R7" : "R2");
      if (k == 2'b01)                return "R6";
      if (k == 2'b10)                return "R5";
      return "R8";
   endfunction

   task automatic compare();
      vectors++;
      if (cc_valid !== x_ccv || (x_ccv && cc !== x_cc) || rd_valid !== x_rdv ||
          (x_rdv && rd_data !== x_rd)) begin
         fails++;
         $display("FAIL %s: got ccv=%0b cc=%b rdv=%0b rd=%h, expected ccv=%0b cc=%b rdv=%0b rd=%h",
                  x_tag, cc_valid, cc, rd_valid, rd_data, x_ccv, x_cc, x_rdv, x_rd);
      end
   endtask

   // drive one cycle of stimulus at a falling edge, check it at the next falling edge
   task automatic step(input logic v, input logic [1:0] k, input logic ev,
                       input logic [W-1:0] eb);
      logic rej;
      logic [W-1:0] add;
      cmd_valid = v; cmd_kind = k; err_valid = ev; err_bits = eb;
      x_tag = pick_tag(v, k, ev, eb, m_dsw);
      rej   = v && is_plain(k) && (m_dsw != '0);
      add   = ev ? eb : '0;
      x_ccv = v;
      x_rdv = v && !rej && (k == 2'b01);
      x_rd  = m_dsw;
      x_cc  = (rej || (ev && eb != '0)) ? 2'b01 : 2'b00;
      if (rej)
         m_dsw = m_dsw;
      else if (v && (k == 2'b01 || k == 2'b10))
         m_dsw = add;
      else
         m_dsw = m_dsw | add;
      @(negedge clk);
      compare();
   endtask

   task automatic idle();
      step(1'b0, 2'b00, 1'b0, '0);
   endtask

   initial begin
      m_dsw = '0;
      repeat (3) @(negedge clk);
      // R1: outputs quiet in reset
      vectors++;
      if (cc_valid !== 1'b0 || rd_valid !== 1'b0) begin
         fails++;
         $display("FAIL R1: got ccv=%0b rdv=%0b, expected 0 0", cc_valid, rd_valid);
      end
      rst_n = 1'b1;
      idle();
      step(1'b1, 2'b01, 1'b0, '0);                 // R1 read after reset returns zero
      step(1'b1, 2'b00, 1'b0, '0);                 // R8 clean accept
      step(1'b1, 2'b11, 1'b1, 16'h0010);           // R2 error with own command
      step(1'b1, 2'b00, 1'b1, 16'h8000);           // R4/R9 rejected, bits dropped
      step(1'b0, 2'b00, 1'b1, 16'h0003);           // R3 merge without command
      step(1'b1, 2'b01, 1'b0, '0);                 // R6 read returns 0013 and clears
      step(1'b1, 2'b00, 1'b0, '0);                 // R8 no longer locked
      step(1'b0, 2'b00, 1'b1, 16'h0100);
      step(1'b1, 2'b10, 1'b0, '0);                 // R5 halt under lockout
      step(1'b1, 2'b01, 1'b0, '0);                 // R5 read confirms clear
      step(1'b0, 2'b00, 1'b1, 16'h0F00);
      step(1'b1, 2'b01, 1'b1, 16'h0001);           // R7 read keeps same-cycle error
      step(1'b1, 2'b10, 1'b1, 16'h4000);           // R7 halt keeps same-cycle error
      step(1'b1, 2'b01, 1'b0, '0);                 // R7 readback 4000
      step(1'b1, 2'b01, 1'b1, 16'h0000);           // R8 strobe with empty mask
      idle();                                      // R10 no stray strobe
      begin
         void'($urandom(32'd1130));
         for (int n = 0; n < 4000; n++) begin
            logic         v  = ($urandom % 3) == 0;
            logic [1:0]   k  = 2'($urandom % 4);
            logic         ev = ($urandom % 7) == 0;
            logic [W-1:0] eb = (($urandom % 5) == 0) ? '0 : (W'(1) << ($urandom % W));
            if (($urandom % 11) == 0) eb = eb | W'($urandom);
            step(v, k, ev, eb);
         end
      end
      step(1'b1, 2'b01, 1'b0, '0);
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         fails++;
         $display("FAIL R10: watchdog expired, got no finish, expected finish");
         $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
         $finish;
      end
   end

endmodule